// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable model of a small serial memory that is reached over a three-wire link. The link uses a select line, a serial clock and a data-in line, and the block drives one data-out line. A host raises select and clocks in a frame. The frame holds a start bit, a two-bit opcode and an address. For write-type commands a data word follows. The host then drops select.

The block supports reading a word, writing a word and erasing a word to all ones. It also supports filling the whole array with ones or with a given word, and turning write permission on or off. Every write-type command starts a self-timed programming period. The period has a fixed length, counted in system clocks. While it runs, data-out reports busy or ready whenever select is high.

The storage is a register array whose depth is set by the address-width parameter. All serial inputs are sampled in the system clock domain. Data in is taken when a rising serial-clock edge is detected while select is high.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame begins with the first serial-clock rising edge that samples data-in at 1 while select is high. Leading 0 bits are skipped. Next come two opcode bits and then ADDR_W address bits, each sent MSB first.
- R2: A new command is accepted only after a rising edge on select. Once a command is complete, further bits clocked in while select stays high have no effect.
- R3: Opcode 10 reads a word. After the last address bit, data-out shows a dummy 0. Each later serial-clock rise then presents the next data bit, MSB first. A read works whether writes are enabled or not.
- R4: Opcode 00 with the two address MSBs at 11 turns writes on. The permission takes effect only when select falls at the end of that frame.
- R5: After reset, writes are disabled, every word reads 0, and data-out is 0.
- R6: Opcode 01 is followed by DATA_W data bits, MSB first, and stores that word at the address.
- R7: Opcode 11 sets the addressed word to all ones.
- R8: Opcode 00 with address MSBs at 10 sets every word to all ones. With address MSBs at 01, it is followed by DATA_W data bits and sets every word to that value. The remaining address bits are ignored.
- R9: Opcode 00 with address MSBs at 00 turns writes off. While writes are off, the write, erase, erase-all and write-all commands change nothing and start no programming period.
- R10: Programming starts on the serial-clock edge that samples the last bit of the command and lasts PROG_CYC system clocks. While select is high during and after that period, data-out is 0 while busy and 1 once ready.
- R11: A command whose select rising edge falls inside a programming period is ignored completely.
- R12: Data-out is 0 while select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out: read data or busy/ready status |

## Verification
The bench checks a frame preceded by leading zeros. A design that does not skip zeros would decode a wrong opcode. It sends a second write while select is still held high after a finished write. A design that does not wait for a new select rising edge would overwrite the word. It starts an erase while a programming period is still running. A design that does not block commands when busy would erase the word just written. Write, erase and both fill commands are also sent after write permission is turned off, and random writes are read back across the whole array. A design that ignores the permission bit, or that reads out of step with the dummy bit, would return wrong words.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [1:0] {
    OP_SPEC  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    SP_DIS   = 2'b00,
    SP_WRALL = 2'b01,
    SP_ERALL = 2'b10,
    SP_EN    = 2'b11
  } spec_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_DONE
  } state_e;
endpackage

// File: rtl/uwire_pins.sv
module uwire_pins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic sk_rise_o
);
  logic cs_q, sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_i;
      sk_q <= sk_i;
    end
  end

  assign cs_rise_o = cs_i & ~cs_q;
  assign cs_fall_o = ~cs_i & cs_q;
  assign sk_rise_o = sk_i & ~sk_q & cs_i;
endmodule

// File: rtl/uwire_timer.sv
module uwire_timer #(
  parameter int PROG_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/uwire_array.sv
module uwire_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill_i || (we_i && (waddr_i == ADDR_W'(i)))) mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int MAXB  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic cs_rise, cs_fall, sk_rise, busy;
  state_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [DATA_W-1:0] data_q, data_nx, out_q, rdata;
  logic do_q, wen_q, en_pend_q, show_q;
  logic last_addr, last_data;
  logic mem_we, mem_fill, prog_go;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  spec_e spec_sel;

  uwire_pins i_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .sk_i      (sk_i),
    .cs_rise_o (cs_rise),
    .cs_fall_o (cs_fall),
    .sk_rise_o (sk_rise)
  );

  uwire_timer #(.PROG_CYC(PROG_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_go),
    .busy_o  (busy)
  );

  uwire_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .fill_i  (mem_fill),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (addr_nx),
    .rdata_o (rdata)
  );

  assign addr_nx   = {addr_q[ADDR_W-2:0], di_i};
  assign data_nx   = {data_q[DATA_W-2:0], di_i};
  assign spec_sel  = spec_e'(addr_nx[ADDR_W-1 -: 2]);
  assign last_addr = sk_rise && (state_q == ST_ADDR) && (cnt_q == ADDR_LAST);
  assign last_data = sk_rise && (state_q == ST_DATA) && (cnt_q == DATA_LAST);
  assign mem_waddr = last_data ? addr_q : addr_nx;

  // commit of write-type commands, gated by write permission
  always_comb begin
    mem_we    = 1'b0;
    mem_fill  = 1'b0;
    mem_wdata = '1;
    if (wen_q) begin
      if (last_addr) begin
        if (opcode_e'(opc_q) == OP_ERASE) mem_we = 1'b1;
        if (opcode_e'(opc_q) == OP_SPEC && spec_sel == SP_ERALL) mem_fill = 1'b1;
      end
      if (last_data) begin
        mem_wdata = data_nx;
        if (opcode_e'(opc_q) == OP_WRITE) mem_we = 1'b1;
        else                              mem_fill = 1'b1;
      end
    end
  end
  assign prog_go = mem_we | mem_fill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      opc_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      out_q     <= '0;
      do_q      <= 1'b0;
      wen_q     <= 1'b0;
      en_pend_q <= 1'b0;
      show_q    <= 1'b0;
    end else begin
      if (cs_fall) begin
        en_pend_q <= 1'b0;
        if (en_pend_q) wen_q <= 1'b1;
        if (!busy) show_q <= 1'b0;
      end
      if (prog_go) show_q <= 1'b1;

      if (!cs_i) begin
        state_q <= ST_IDLE;
        do_q    <= 1'b0;
      end else if (cs_rise) begin
        state_q <= busy ? ST_IDLE : ST_START;
        cnt_q   <= '0;
        do_q    <= 1'b0;
      end else if (sk_rise) begin
        unique case (state_q)
          ST_START: if (di_i) begin
            state_q <= ST_OPC;
            cnt_q   <= '0;
            show_q  <= 1'b0;
          end
          ST_OPC: begin
            opc_q <= {opc_q[0], di_i};
            if (cnt_q == CNT_W'(1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_ADDR: begin
            addr_q <= addr_nx;
            if (last_addr) begin
              cnt_q <= '0;
              unique case (opcode_e'(opc_q))
                OP_READ: begin
                  state_q <= ST_READ;
                  out_q   <= rdata;
                  do_q    <= 1'b0;
                end
                OP_WRITE: state_q <= ST_DATA;
                OP_ERASE: state_q <= ST_DONE;
                OP_SPEC: begin
                  state_q <= (spec_sel == SP_WRALL) ? ST_DATA : ST_DONE;
                  if (spec_sel == SP_EN)  en_pend_q <= 1'b1;
                  if (spec_sel == SP_DIS) wen_q     <= 1'b0;
                end
                default: state_q <= ST_DONE;
              endcase
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            data_q <= data_nx;
            if (last_data) state_q <= ST_DONE;
            else           cnt_q   <= cnt_q + 1'b1;
          end
          ST_READ: begin
            do_q  <= out_q[DATA_W-1];
            out_q <= {out_q[DATA_W-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  assign do_o = cs_i & (show_q ? ~busy : do_q);
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk
  import uwire_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   cs_i,
  input logic   do_o,
  input logic   busy,
  input logic   wen,
  input logic   cs_fall,
  input state_e state
);
  a_r4_wen_at_cs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wen) |-> $past(cs_fall));

  a_r9_prog_needs_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wen));

  a_r10_busy_shows_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && busy) |-> !do_o);

  a_r11_busy_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && state == ST_IDLE) |=> state == ST_IDLE);

  a_r2_cs_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> state == ST_IDLE);

  a_r12_cs_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !do_o);
endmodule

bind uwire_eeprom uwire_eeprom_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .do_o    (do_o),
  .busy    (busy),
  .wen     (wen_q),
  .cs_fall (cs_fall),
  .state   (state_q)
);

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int PROG_CYC = 40;
  localparam int DEPTH    = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DATA_W-1:0] mdl [DEPTH];
  bit mwen = 1'b0;

  always #10 clk = ~clk;

  uwire_eeprom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)) i_uwire_eeprom (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_i   (cs),
    .sk_i   (sk),
    .di_i   (di),
    .do_o   (do_w)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] exp_word(input int a);
    return mdl[a];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) di = b;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    b = do_w;
    sk = 1'b0;
  endtask

  task automatic cs_up();
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) begin cs = 1'b0; di = 1'b0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic send_head(input logic [1:0] op, input logic [ADDR_W-1:0] a);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = ADDR_W - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [DATA_W-1:0] d);
    for (int i = DATA_W - 1; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic wait_prog();
    repeat (PROG_CYC + 8) @(negedge clk);
  endtask

  task automatic cmd_write(input int a, input logic [DATA_W-1:0] d);
    cs_up(); send_head(2'b01, ADDR_W'(a)); send_word(d); cs_down();
    if (mwen) mdl[a] = d;
    wait_prog();
  endtask

  task automatic cmd_erase(input int a);
    cs_up(); send_head(2'b11, ADDR_W'(a)); cs_down();
    if (mwen) mdl[a] = '1;
    wait_prog();
  endtask

  task automatic cmd_eral();
    cs_up(); send_head(2'b00, {2'b10, {(ADDR_W-2){1'b0}}}); cs_down();
    if (mwen) for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
    wait_prog();
  endtask

  task automatic cmd_wral(input logic [DATA_W-1:0] d);
    cs_up(); send_head(2'b00, {2'b01, {(ADDR_W-2){1'b1}}}); send_word(d); cs_down();
    if (mwen) for (int i = 0; i < DEPTH; i++) mdl[i] = d;
    wait_prog();
  endtask

  task automatic cmd_en();
    cs_up(); send_head(2'b00, {2'b11, {(ADDR_W-2){1'b0}}}); cs_down();
    mwen = 1'b1;
  endtask

  task automatic cmd_dis();
    cs_up(); send_head(2'b00, {2'b00, {(ADDR_W-2){1'b1}}}); cs_down();
    mwen = 1'b0;
  endtask

  task automatic read_tail(output logic [DATA_W-1:0] d, output logic dummy);
    dummy = do_w;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      logic b;
      read_bit(b);
      d[i] = b;
    end
  endtask

  task automatic check_read(input int a, input string req);
    logic [DATA_W-1:0] d;
    logic dummy;
    cs_up(); send_head(2'b10, ADDR_W'(a)); read_tail(d, dummy); cs_down();
    check(dummy == 1'b0, {req, " dummy"}, int'(dummy), 0);
    check(d == exp_word(a), req, int'(d), int'(exp_word(a)));
  endtask

  initial begin
    logic [DATA_W-1:0] d;
    logic dummy;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check(do_w == 1'b0, "R5 reset do", int'(do_w), 0);
    check_read(5, "R5/R3 reset read while disabled");
    check_read(DEPTH - 1, "R5 reset top word");

    cmd_write(5, 8'hA5);
    check_read(5, "R9 write ignored after reset");

    cmd_en();
    cmd_write(5, 8'hA5);
    check_read(5, "R4/R6 write after enable");

    // R1: leading zeros ahead of the start bit
    cs_up(); send_bit(1'b0); send_bit(1'b0); send_head(2'b10, 6'd5);
    read_tail(d, dummy); cs_down();
    check(dummy == 1'b0, "R1 dummy after zeros", int'(dummy), 0);
    check(d == exp_word(5), "R1 read after zeros", int'(d), int'(exp_word(5)));

    // R10 status, then R2 no second command without select edge
    cs_up(); send_head(2'b01, 6'd9); send_word(8'h3C);
    check(do_w == 1'b0, "R10 busy low", int'(do_w), 0);
    repeat (PROG_CYC) @(negedge clk);
    check(do_w == 1'b1, "R10 ready high", int'(do_w), 1);
    send_head(2'b01, 6'd9); send_word(8'hFF);
    cs_down();
    mdl[9] = 8'h3C;
    wait_prog();
    check_read(9, "R2 held select no second write");

    // R11: command started while programming is ignored
    cs_up(); send_head(2'b01, 6'd10); send_word(8'h77); cs_down();
    cs_up(); send_head(2'b11, 6'd10); cs_down();
    mdl[10] = 8'h77;
    wait_prog();
    check_read(10, "R11 erase during busy ignored");

    cmd_erase(10);
    check_read(10, "R7 erase to ones");

    for (int n = 0; n < 20; n++) begin
      int a;
      a = int'($urandom % DEPTH);
      cmd_write(a, DATA_W'($urandom));
    end
    for (int a = 0; a < DEPTH; a++) check_read(a, "R6 random readback");

    cmd_eral();
    check_read(0, "R8 erase-all low");
    check_read(31, "R8 erase-all mid");
    check_read(DEPTH - 1, "R8 erase-all top");
    cmd_wral(8'h5A);
    check_read(0, "R8 write-all low");
    check_read(17, "R8 write-all mid");
    check_read(DEPTH - 1, "R8 write-all top");

    cmd_dis();
    cmd_write(3, 8'h00);
    check_read(3, "R9 write after disable");
    cmd_erase(4);
    check_read(4, "R9 erase after disable");
    cmd_eral();
    check_read(20, "R9 erase-all after disable");
    cmd_wral(8'h00);
    check_read(40, "R9/R3 write-all after disable, read works");

    check(do_w == 1'b0, "R12 select low do", int'(do_w), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule